// File: doc/BRIEF.md
# Programmable Hold PWM Generator

This block produces one pulse-width-modulated output for holding a load at a reduced average level. A free-running 8-bit step counter moves from zero up to a programmable ceiling and then wraps. The output is high while the counter sits below a programmable mark value. The counter advances only on a prescaled enable whose ratio is a power of two, chosen by a 4-bit rate code.

Three setting inputs (mark, ceiling, rate code) are captured together by a one-cycle load strobe into a staging bank. While the generator runs, the staged values move into the working bank only at a counter wrap, so every period that is output is a whole period under a single set of settings. A run input turns the generator off: the output drops at once and the counter and prescaler are held at zero.

Top module: `pwm_hold_gen`

## Requirements
- R1: After reset the settings are mark 127, ceiling 255 and rate code 5 (one counter step per 16 clocks), and the output is low whenever the run input is low.
- R2: With run high, the step counter starts at 0, advances by one on each prescaled tick, and returns to 0 on the tick after it reaches the ceiling, so a period lasts (ceiling+1) ticks.
- R3: With run high and a mark below 255, the output is high exactly while the step counter is below the mark; a mark of 0 keeps the output low.
- R4: A mark of 255 keeps the output high for the whole period whatever the ceiling; a mark above the ceiling also keeps it high throughout.
- R5: Rate code n (1 to 15) makes one counter step last 2^(n-1) clocks, from 1 clock for code 1 to 16384 clocks for code 15.
- R6: A rate code of 0 is stored and used as code 1.
- R7: Settings present on the inputs in a cycle with load high are captured at that clock edge; while running, they replace the working settings only at the edge where the counter wraps, and the period in progress ends under the old settings.
- R8: When run goes low the output is low in that same cycle, the counter and prescaler are cleared at the next edge and held at zero, and captured settings become the working settings; when run returns high the first period starts from step 0.
- R9: Changes on the setting inputs while load is low have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_en | input | 1 | High to generate; low forces the output low and holds the counter at zero |
| cfg_load | input | 1 | One-cycle strobe that captures the three setting inputs |
| mark_in | input | 8 | Compare value; output high while the counter is below it, 255 means always high |
| ceil_in | input | 8 | Highest counter value before the wrap |
| rate_in | input | 4 | Prescale code, one step per 2^(code-1) clocks, 0 read as 1 |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The hardest case to reach is a load that arrives in the middle of a running period, because the new settings must stay invisible until the exact wrap edge and only a cycle-level view of the output shows a premature switch. The stimulus starts a short, slowly ticking period, raises the load a few cycles in, and expects the old waveform up to the wrap and the new one from the following cycle; a second run changes the setting inputs without any load and expects no change across two full periods. The slowest rate code is run through a full period so the widest prescale limit is covered as well.

// File: rtl/pwm_hold_pkg.sv
package pwm_hold_pkg;

  // Width of the step counter and of the mark and ceiling values.
  localparam int unsigned STEP_W = 8;
  // Width of the prescale rate code.
  localparam int unsigned CODE_W = 4;

  // Values taken by the settings when reset is applied.
  localparam logic [STEP_W-1:0] MARK_RST = 8'd127;
  localparam logic [STEP_W-1:0] CEIL_RST = 8'd255;
  localparam logic [CODE_W-1:0] RATE_RST = 4'd5;

  // A code of zero is out of range and is read as the fastest rate.
  function automatic logic [CODE_W-1:0] legal_code(input logic [CODE_W-1:0] code);
    return (code == '0) ? CODE_W'(1) : code;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned CODE_W   = 4,
  localparam int unsigned MAX_CODE = (1 << CODE_W) - 1,
  localparam int unsigned PRE_W    = MAX_CODE - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] limit;
  logic             at_limit;

  // Terminal count for each legal code, 2^(code-1)-1.
  always_comb begin
    limit = '0;
    for (int i = 1; i <= int'(MAX_CODE); i++) begin
      if (code == CODE_W'(i)) begin
        limit = PRE_W'((32'd1 << (i - 1)) - 32'd1);
      end
    end
  end

  assign at_limit = (pre_q >= limit);
  assign tick     = run && at_limit;

  always_comb begin
    if (!run) begin
      pre_d = '0;
    end else if (at_limit) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  // R5: a tick is followed by a gap unless the rate is one step per clock.
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || limit == '0));

  // R8: the prescaler is cleared while stopped.
  p_pre_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));

endmodule

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_hold_pkg::*;
#(
  parameter int unsigned STEP_W_P = STEP_W,
  parameter int unsigned CODE_W_P = CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                wrap,
  input  logic                load,
  input  logic [STEP_W_P-1:0] mark_in,
  input  logic [STEP_W_P-1:0] ceil_in,
  input  logic [CODE_W_P-1:0] rate_in,
  output logic [STEP_W_P-1:0] mark_act,
  output logic [STEP_W_P-1:0] ceil_act,
  output logic [CODE_W_P-1:0] rate_act
);

  logic [STEP_W_P-1:0] mark_stg_q, mark_stg_d;
  logic [STEP_W_P-1:0] ceil_stg_q, ceil_stg_d;
  logic [CODE_W_P-1:0] rate_stg_q, rate_stg_d;
  logic [STEP_W_P-1:0] mark_act_q, mark_act_d;
  logic [STEP_W_P-1:0] ceil_act_q, ceil_act_d;
  logic [CODE_W_P-1:0] rate_act_q, rate_act_d;
  logic                apply;

  // Working bank follows the staging bank at a wrap or while stopped.
  assign apply = wrap || !run;

  always_comb begin
    mark_stg_d = mark_stg_q;
    ceil_stg_d = ceil_stg_q;
    rate_stg_d = rate_stg_q;
    if (load) begin
      mark_stg_d = mark_in;
      ceil_stg_d = ceil_in;
      rate_stg_d = (rate_in == '0) ? CODE_W_P'(1) : rate_in;
    end
  end

  always_comb begin
    mark_act_d = mark_act_q;
    ceil_act_d = ceil_act_q;
    rate_act_d = rate_act_q;
    if (apply) begin
      mark_act_d = mark_stg_q;
      ceil_act_d = ceil_stg_q;
      rate_act_d = rate_stg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_stg_q <= STEP_W_P'(MARK_RST);
      ceil_stg_q <= STEP_W_P'(CEIL_RST);
      rate_stg_q <= CODE_W_P'(RATE_RST);
    end else begin
      mark_stg_q <= mark_stg_d;
      ceil_stg_q <= ceil_stg_d;
      rate_stg_q <= rate_stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_act_q <= STEP_W_P'(MARK_RST);
      ceil_act_q <= STEP_W_P'(CEIL_RST);
      rate_act_q <= CODE_W_P'(RATE_RST);
    end else begin
      mark_act_q <= mark_act_d;
      ceil_act_q <= ceil_act_d;
      rate_act_q <= rate_act_d;
    end
  end

  assign mark_act = mark_act_q;
  assign ceil_act = ceil_act_q;
  assign rate_act = rate_act_q;

  // R7: working settings do not move in the middle of a running period.
  p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(mark_act_q) && $stable(ceil_act_q) && $stable(rate_act_q)));

  // R6: a zero rate code is stored as code 1.
  p_code_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rate_in == '0) |=> (rate_stg_q == CODE_W_P'(1)));

  // R9: without a load strobe the staging bank keeps its contents.
  p_stage_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mark_stg_q) && $stable(ceil_stg_q) && $stable(rate_stg_q)));

endmodule

// File: rtl/pwm_step_cmp.sv
module pwm_step_cmp #(
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [STEP_W-1:0] mark,
  input  logic [STEP_W-1:0] ceiling,
  output logic              wrap,
  output logic              pwm
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic              at_ceil;
  logic              full_on;

  assign at_ceil = (step_q == ceiling);
  assign wrap    = tick && at_ceil;

  always_comb begin
    if (!run) begin
      step_d = '0;
    end else if (wrap) begin
      step_d = '0;
    end else if (tick) begin
      step_d = step_q + STEP_W'(1);
    end else begin
      step_d = step_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else begin
      step_q <= step_d;
    end
  end

  // All-ones mark is the full-on code.
  assign full_on = &mark;
  assign pwm     = run && (full_on || (step_q < mark));

  // R2: the counter never passes the working ceiling.
  p_step_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= ceiling);

  // R8: the counter is held at zero while stopped.
  p_step_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (step_q == '0));

  // R2: between ticks the counter stands still.
  p_step_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(step_q));

endmodule

// File: rtl/pwm_hold_gen.sv
module pwm_hold_gen
  import pwm_hold_pkg::*;
#(
  parameter int unsigned STEP_BITS = STEP_W,
  parameter int unsigned CODE_BITS = CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_en,
  input  logic                 cfg_load,
  input  logic [STEP_BITS-1:0] mark_in,
  input  logic [STEP_BITS-1:0] ceil_in,
  input  logic [CODE_BITS-1:0] rate_in,
  output logic                 pwm_out
);

  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  logic                 tick;
  logic                 wrap;
  logic [STEP_BITS-1:0] mark_act;
  logic [STEP_BITS-1:0] ceil_act;
  logic [CODE_BITS-1:0] rate_act;

  // Reset asserts at once and leaves two clock edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  pwm_cfg_regs #(
    .STEP_W_P (STEP_BITS),
    .CODE_W_P (CODE_BITS)
  ) cfg_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (run_en),
    .wrap     (wrap),
    .load     (cfg_load),
    .mark_in  (mark_in),
    .ceil_in  (ceil_in),
    .rate_in  (rate_in),
    .mark_act (mark_act),
    .ceil_act (ceil_act),
    .rate_act (rate_act)
  );

  pwm_prescaler #(
    .CODE_W (CODE_BITS)
  ) pre_i (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (run_en),
    .code  (rate_act),
    .tick  (tick)
  );

  pwm_step_cmp #(
    .STEP_W (STEP_BITS)
  ) step_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run_en),
    .tick    (tick),
    .mark    (mark_act),
    .ceiling (ceil_act),
    .wrap    (wrap),
    .pwm     (pwm_out)
  );

  // R4: full-on mark holds the output high for as long as the block runs.
  p_full_on_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en && mark_act == '1) |-> pwm_out);

  // R1: a stopped block never drives its output high.
  p_stopped_low_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run_en |-> !pwm_out);

  // R6: the working rate code is never zero.
  p_rate_legal_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    rate_act != '0);

endmodule

// File: tb/pwm_hold_gen_tb_top.sv
module pwm_hold_gen_tb_top;

  typedef struct {
    bit    val;
    string req;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       run_en;
  logic       cfg_load;
  logic [7:0] mark_in;
  logic [7:0] ceil_in;
  logic [3:0] rate_in;
  logic       pwm_out;

  exp_t q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   stim_done = 0;
  bit   finished  = 0;

  pwm_hold_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .cfg_load (cfg_load),
    .mark_in  (mark_in),
    .ceil_in  (ceil_in),
    .rate_in  (rate_in),
    .pwm_out  (pwm_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected output k cycles after run was raised, from the requirements.
  function automatic bit model(int k, int mark, int ceil, int code);
    int c;
    int presc;
    int step;
    c = (code == 0) ? 1 : code;
    presc = 1 << (c - 1);
    if (mark == 255) return 1'b1;
    step = (k / presc) % (ceil + 1);
    return (step < mark);
  endfunction

  task automatic push_exp(bit v, string r);
    exp_t e;
    #1;
    e.val = v;
    e.req = r;
    q.push_back(e);
  endtask

  // Capture settings while stopped; they become active before run is raised.
  task automatic configure(int mark, int ceil, int code);
    @(negedge clk);
    run_en   = 1'b0;
    cfg_load = 1'b1;
    mark_in  = 8'(mark);
    ceil_in  = 8'(ceil);
    rate_in  = 4'(code);
    push_exp(1'b0, "R8");
    @(negedge clk);
    cfg_load = 1'b0;
    push_exp(1'b0, "R8");
    @(negedge clk);
    push_exp(1'b0, "R8");
  endtask

  task automatic run_pattern(int n, int mark, int ceil, int code, string r);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      run_en = 1'b1;
      push_exp(model(k, mark, ceil, code), r);
    end
  endtask

  // Monitor: compares each expected item against the sampled output.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (pwm_out !== e.val) begin
          n_errors++;
          $display("FAIL %s at %0t: pwm_out=%b expected=%b", e.req, $time, pwm_out, e.val);
        end
      end
    end
  end

  // Driver.
  initial begin
    rst_n    = 1'b0;
    run_en   = 1'b0;
    cfg_load = 1'b0;
    mark_in  = 8'd0;
    ceil_in  = 8'd0;
    rate_in  = 4'd0;
    repeat (3) @(negedge clk);
    // R1: output low during reset.
    push_exp(1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      push_exp(1'b0, "R1");
    end

    // R1: defaults 127 / 255 / code 5, two full periods.
    run_pattern(2 * 256 * 16, 127, 255, 5, "R1");

    // R2, R3: fast rate, short period.
    configure(3, 7, 1);
    run_pattern(32, 3, 7, 1, "R2");

    // R3: mark 0 never high.
    configure(0, 4, 2);
    run_pattern(40, 0, 4, 2, "R3");

    // R4: mark 255 with ceiling 255.
    configure(255, 255, 1);
    run_pattern(600, 255, 255, 1, "R4");

    // R4: mark above ceiling.
    configure(10, 5, 3);
    run_pattern(96, 10, 5, 3, "R4");

    // R6: code 0 acts as code 1.
    configure(2, 3, 0);
    run_pattern(24, 2, 3, 1, "R6");

    // R5: slowest rate, one full period plus a step.
    configure(1, 1, 15);
    run_pattern(2 * 16384 + 16384, 1, 1, 15, "R5");

    // R5: middle rate.
    configure(2, 3, 4);
    run_pattern(80, 2, 3, 4, "R5");

    // R7: load while running takes effect at the wrap (step k=8).
    configure(2, 3, 2);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      run_en = 1'b1;
      if (k == 3) begin
        cfg_load = 1'b1;
        mark_in  = 8'd1;
        ceil_in  = 8'd1;
        rate_in  = 4'd1;
      end else begin
        cfg_load = 1'b0;
      end
      if (k < 8) push_exp(model(k, 2, 3, 2), "R7");
      else       push_exp(model(k - 8, 1, 1, 1), "R7");
    end

    // R9: setting inputs change without load, output unchanged.
    configure(2, 3, 2);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      run_en = 1'b1;
      if (k == 2) begin
        mark_in = 8'd200;
        ceil_in = 8'd9;
        rate_in = 4'd7;
      end
      push_exp(model(k, 2, 3, 2), "R9");
    end

    // R8: stop mid-period, output low at once, restart from step 0.
    configure(5, 7, 1);
    run_pattern(5, 5, 7, 1, "R8");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      run_en = 1'b0;
      push_exp(1'b0, "R8");
    end
    run_pattern(20, 5, 7, 1, "R8");

    @(negedge clk);
    run_en = 1'b0;
    repeat (4) @(negedge clk);
    stim_done = 1'b1;
  end

  // Summary once stimulus ends and the queue is drained.
  initial begin
    wait (stim_done && q.size() == 0);
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: stimulus_done=%b expected=1", stim_done);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule